// File: doc/BRIEF.md
# Prescaled PWM channel pair

The block generates two independent pulse-width modulated outputs, each configured through a small synchronous register bus. A channel divides the input clock by a programmable prescaler to form counting ticks. It counts one period of ticks and holds its output high for a programmed number of ticks at the start of every period. A flag in the duty register forces the output high for the whole period.

Each channel has its own enable input. Settings written while a channel runs are held back until the current period ends, so a pulse is never cut short or stretched. A per-channel stop-mode bit chooses what happens when the enable drops. Either the current period runs to its end and the output then parks low, or the output drops on the next clock.

Top module: `pwm_pair`

## Requirements
- R1: After reset every register reads 0 and both outputs are low.
- R2: Channel c has its registers at byte offset 0x10*c. The control register at +0x00 holds the prescaler in bits [5:0] and the stop-mode bit in bit 6. The duty register at +0x04 holds the duty count DC in bits [9:0] and the full-high flag in bit 10. The period register at +0x08 holds PV in bits [9:0]. Bus bits [1:0] are ignored. A read returns the written value of those bits and 0 in every other bit. Offset +0x0C reads 0. Read data is combinational from the address, and a write takes effect at the clock edge where the write enable is high.
- R3: With prescaler 0 a period lasts PV+1 clocks and the output is high for the first DC clocks. The first period starts with the clock edge that first samples the enable high.
- R4: With prescaler P, each count lasts P+1 clocks. A period then lasts (P+1)*(PV+1) clocks, and the output is high for the first (P+1)*DC of them.
- R5: With the full-high flag set, the output stays high for the whole period whatever DC holds.
- R6: DC = 0 with the flag clear gives a constant low output. DC >= PV+1 gives a constant high output.
- R7: Prescaler, duty, flag and period values written during a period take effect only from the next period.
- R8: When the enable is low and the stop-mode bit is 0, the channel finishes its current period and then holds its output low.
- R9: When the enable is low and the stop-mode bit is 1, the output goes low right after the next clock edge.
- R10: The two channels run independently, each from its own registers and its own enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Register byte address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| chan_en | input | 2 | Per-channel enable |
| pwm_out | output | 2 | Per-channel PWM output |

## Verification
The bench builds the block with its default of two channels, so the address decode reaches the second register window. Both outputs can be compared in the same cycle while the channels run different periods. Prescalers of 0, 1 and 2 and periods of 3 to 12 counts keep each waveform short enough to check every clock over several periods. These values also reach the boundary reload, both stop modes and the saturating duty values.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  localparam int PRE_W    = 6;
  localparam int CNT_W    = 10;
  localparam int SD_BIT   = 6;
  localparam int FULL_BIT = 10;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_DUTY = 2'd1,
    REG_PER  = 2'd2,
    REG_NONE = 2'd3
  } reg_idx_t;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic             sd;
    logic [CNT_W-1:0] dc;
    logic             full;
    logic [CNT_W-1:0] pv;
  } chan_cfg_t;

  // level of the output for a given count position
  function automatic logic pulse_level(input logic [CNT_W-1:0] cnt,
                                       input logic [CNT_W-1:0] dc,
                                       input logic full);
    return full || (cnt < dc);
  endfunction

  // a counting tick is due when the prescale counter has reached its limit
  function automatic logic tick_due(input logic [PRE_W-1:0] pc,
                                    input logic [PRE_W-1:0] pre);
    return pc == pre;
  endfunction
endpackage

// File: rtl/pwm_pair_regs.sv
module pwm_pair_regs
  import pwm_pair_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   we,
  input  logic [DATA_W-1:0]      wdata,
  output logic [DATA_W-1:0]      rdata,
  output chan_cfg_t [NCH-1:0]    cfg
);
  localparam int CH_W = ADDR_W - 4;

  logic [CH_W-1:0] ch_idx;
  reg_idx_t        reg_idx;
  logic            unused_bits;

  assign ch_idx      = addr[ADDR_W-1:4];
  assign reg_idx     = reg_idx_t'(addr[3:2]);
  assign unused_bits = ^{wdata[DATA_W-1:FULL_BIT+1], addr[1:0]};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg[c] <= '0;
      end else if (we && ch_idx == CH_W'(c)) begin
        case (reg_idx)
          REG_CTRL: begin
            cfg[c].pre <= wdata[PRE_W-1:0];
            cfg[c].sd  <= wdata[SD_BIT];
          end
          REG_DUTY: begin
            cfg[c].dc   <= wdata[CNT_W-1:0];
            cfg[c].full <= wdata[FULL_BIT];
          end
          REG_PER:  cfg[c].pv <= wdata[CNT_W-1:0];
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (int'(ch_idx) < NCH) begin
      case (reg_idx)
        REG_CTRL: rdata = DATA_W'({cfg[ch_idx].sd, cfg[ch_idx].pre});
        REG_DUTY: rdata = DATA_W'({cfg[ch_idx].full, cfg[ch_idx].dc});
        REG_PER:  rdata = DATA_W'(cfg[ch_idx].pv);
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pwm_pair_chan.sv
module pwm_pair_chan
  import pwm_pair_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  chan_cfg_t        cfg,
  output logic             pwm_o,
  output logic             run_o,
  output logic             tick_o,
  output logic             bnd_o,
  output logic             start_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] act_dc_o,
  output logic [CNT_W-1:0] act_pv_o,
  output logic             act_full_o
);
  logic             run;
  logic [PRE_W-1:0] pc;
  logic [CNT_W-1:0] cnt;
  logic [PRE_W-1:0] act_pre;
  logic [CNT_W-1:0] act_dc;
  logic [CNT_W-1:0] act_pv;
  logic             act_full;

  logic tick, bnd, start, hard_stop, soft_stop;

  assign tick      = run && tick_due(pc, act_pre);
  assign bnd       = tick && (cnt == act_pv);
  assign start     = !run && en;
  assign hard_stop = run && !en && cfg.sd;
  assign soft_stop = bnd && !en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= 1'b0;
      pc       <= '0;
      cnt      <= '0;
      act_pre  <= '0;
      act_dc   <= '0;
      act_pv   <= '0;
      act_full <= 1'b0;
    end else if (start) begin
      run      <= 1'b1;
      pc       <= '0;
      cnt      <= '0;
      act_pre  <= cfg.pre;
      act_dc   <= cfg.dc;
      act_pv   <= cfg.pv;
      act_full <= cfg.full;
    end else if (run) begin
      if (hard_stop || soft_stop) begin
        run <= 1'b0;
        pc  <= '0;
        cnt <= '0;
      end else if (tick) begin
        pc <= '0;
        if (bnd) begin
          cnt      <= '0;
          act_pre  <= cfg.pre;
          act_dc   <= cfg.dc;
          act_pv   <= cfg.pv;
          act_full <= cfg.full;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        pc <= pc + 1'b1;
      end
    end
  end

  assign pwm_o      = run && pulse_level(cnt, act_dc, act_full);
  assign run_o      = run;
  assign tick_o     = tick;
  assign bnd_o      = bnd;
  assign start_o    = start;
  assign cnt_o      = cnt;
  assign act_dc_o   = act_dc;
  assign act_pv_o   = act_pv;
  assign act_full_o = act_full;
endmodule

// File: rtl/pwm_pair.sv
module pwm_pair
  import pwm_pair_pkg::*;
#(
  parameter  int NCH    = 2,
  parameter  int DATA_W = 32,
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int ADDR_W = CH_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NCH-1:0]    chan_en,
  output logic [NCH-1:0]    pwm_out
);
  chan_cfg_t [NCH-1:0] cfg;

  logic [NCH-1:0]            run_w, tick_w, bnd_w, start_w, sd_w, act_full_w;
  logic [NCH-1:0][CNT_W-1:0] cnt_w, act_dc_w, act_pv_w;

  pwm_pair_regs #(.NCH(NCH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (bus_addr),
    .we    (bus_we),
    .wdata (bus_wdata),
    .rdata (bus_rdata),
    .cfg   (cfg)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign sd_w[c] = cfg[c].sd;
    pwm_pair_chan u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (chan_en[c]),
      .cfg        (cfg[c]),
      .pwm_o      (pwm_out[c]),
      .run_o      (run_w[c]),
      .tick_o     (tick_w[c]),
      .bnd_o      (bnd_w[c]),
      .start_o    (start_w[c]),
      .cnt_o      (cnt_w[c]),
      .act_dc_o   (act_dc_w[c]),
      .act_pv_o   (act_pv_w[c]),
      .act_full_o (act_full_w[c])
    );
  end
endmodule

// File: rtl/pwm_pair_chk.sv
module pwm_pair_chk
  import pwm_pair_pkg::*;
#(
  parameter int NCH = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NCH-1:0]             chan_en,
  input logic [NCH-1:0]             pwm_out,
  input logic [NCH-1:0]             run,
  input logic [NCH-1:0]             tick,
  input logic [NCH-1:0]             bnd,
  input logic [NCH-1:0]             start,
  input logic [NCH-1:0]             sd,
  input logic [NCH-1:0]             act_full,
  input logic [NCH-1:0][CNT_W-1:0]  cnt,
  input logic [NCH-1:0][CNT_W-1:0]  act_dc,
  input logic [NCH-1:0][CNT_W-1:0]  act_pv
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      run[c] |-> cnt[c] <= act_pv[c]); // R3

    AST_BOUNDARY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (bnd[c] && chan_en[c]) |=> (run[c] && cnt[c] == '0)); // R3

    AST_BOUNDARY_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      bnd[c] |-> tick[c]); // R4

    AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      start[c] |=> (run[c] && cnt[c] == '0 &&
                    pwm_out[c] == (act_full[c] || act_dc[c] != '0))); // R3

    AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (run[c] && act_full[c]) |-> pwm_out[c]); // R5

    AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (run[c] && !act_full[c] && act_dc[c] == '0) |-> !pwm_out[c]); // R6

    AST_SETTINGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (run[c] && !bnd[c]) |=> ($stable(act_dc[c]) && $stable(act_pv[c]) &&
                               $stable(act_full[c]))); // R7

    AST_SOFT_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (run[c] && !chan_en[c] && !sd[c] && !bnd[c]) |=> run[c]); // R8

    AST_HARD_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (run[c] && !chan_en[c] && sd[c]) |=> (!run[c] && !pwm_out[c])); // R9
  end
endmodule

bind pwm_pair pwm_pair_chk #(.NCH(NCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .chan_en  (chan_en),
  .pwm_out  (pwm_out),
  .run      (run_w),
  .tick     (tick_w),
  .bnd      (bnd_w),
  .start    (start_w),
  .sd       (sd_w),
  .act_full (act_full_w),
  .cnt      (cnt_w),
  .act_dc   (act_dc_w),
  .act_pv   (act_pv_w)
);

// File: tb/pwm_pair_bench.sv
`timescale 1ns/100ps
module pwm_pair_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  chan_en = '0;
  logic [1:0]  pwm_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [1:0] exp;
    logic [1:0] mask;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  pwm_pair u_pwm_pair (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .chan_en   (chan_en),
    .pwm_out   (pwm_out)
  );

  // expected level k clocks after the start of a run, from the period rules
  function automatic logic model_bit(int pre, int dc, int full, int pv, int k);
    int per = (pre + 1) * (pv + 1);
    int eff = full != 0 ? pv + 1 : (dc > pv + 1 ? pv + 1 : dc);
    return (k % per) < (pre + 1) * eff;
  endfunction

  task automatic push(logic [1:0] e, logic [1:0] m, string tag);
    item_t it;
    it.exp = e; it.mask = m; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: one scoreboard item per clock, sampled at the falling edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_cmp++;
      if ((pwm_out & it.mask) !== (it.exp & it.mask)) begin
        n_bad++;
        $display("FAIL %s: pwm_out=%b expected=%b (mask %b) at %0t",
                 it.tag, pwm_out, it.exp, it.mask, $time);
      end
    end
  end

  // all driver tasks start and end 1 ns after a rising edge
  task automatic bus_wr(int ch, int idx, logic [31:0] val);
    bus_addr  = 5'((ch << 4) | (idx << 2));
    bus_wdata = val;
    bus_we    = 1'b1;
    @(posedge clk); #1;
    bus_we    = 1'b0;
  endtask

  task automatic bus_rd_chk(logic [4:0] a, logic [31:0] exp, string tag);
    bus_addr = a;
    bus_we   = 1'b0;
    #0.5;
    n_cmp++;
    if (bus_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: read %h = %h expected %h", tag, a, bus_rdata, exp);
    end
    @(posedge clk); #1;
  endtask

  task automatic cfg_ch(int ch, int pre, int sd, int dc, int full, int pv);
    bus_wr(ch, 0, 32'((sd << 6) | pre));
    bus_wr(ch, 1, 32'((full << 10) | dc));
    bus_wr(ch, 2, 32'(pv));
  endtask

  task automatic wait_drain();
    while (sb_q.size() > 0) @(posedge clk);
    #1;
  endtask

  task automatic stop_ch(int ch);
    bus_wr(ch, 0, 32'h40);
    chan_en[ch] = 1'b0;
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic run_single(int ch, int pre, int dc, int full, int pv, int ncyc, string tag);
    logic [1:0] m = 2'(1 << ch);
    cfg_ch(ch, pre, 0, dc, full, pv);
    push(2'b00, m, tag);
    for (int k = 0; k < ncyc; k++)
      push(2'(model_bit(pre, dc, full, pv, k)) << ch, m, tag);
    chan_en[ch] = 1'b1;
    wait_drain();
    stop_ch(ch);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    n_cmp++;
    if (pwm_out !== 2'b00) begin
      n_bad++;
      $display("FAIL R1: pwm_out=%b expected=00 in reset", pwm_out);
    end
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: all registers zero after reset
    for (int ch = 0; ch < 2; ch++)
      for (int idx = 0; idx < 3; idx++)
        bus_rd_chk(5'((ch << 4) | (idx << 2)), 32'h0, "R1");

    // R2: field masking, window offset, ignored low address bits
    bus_wr(0, 0, 32'hFFFF_FFFF);
    bus_wr(0, 1, 32'hFFFF_FFFF);
    bus_wr(0, 2, 32'hFFFF_FFFF);
    bus_rd_chk(5'h00, 32'h7F,  "R2");
    bus_rd_chk(5'h04, 32'h7FF, "R2");
    bus_rd_chk(5'h08, 32'h3FF, "R2");
    bus_rd_chk(5'h07, 32'h7FF, "R2");
    bus_rd_chk(5'h0C, 32'h0,   "R2");
    bus_rd_chk(5'h10, 32'h0,   "R10");
    bus_wr(1, 0, 32'h15);
    bus_rd_chk(5'h10, 32'h15,  "R2");
    bus_rd_chk(5'h00, 32'h7F,  "R10");

    // R3: prescaler 0, period 8, high 3
    run_single(0, 0, 3, 0, 7, 24, "R3");
    // R4: prescaled periods on both channels
    run_single(0, 2, 2, 0, 4, 45, "R4");
    run_single(1, 1, 3, 0, 5, 24, "R4");
    // R5: full-high flag overrides DC
    run_single(0, 0, 1, 1, 7, 16, "R5");
    // R6: zero duty and saturated duty
    run_single(0, 0, 0, 0, 7, 16, "R6");
    run_single(0, 0, 9, 0, 7, 16, "R6");
    run_single(1, 0, 8, 0, 7, 16, "R6");

    // R7: duty and period written mid-period apply from the next period
    cfg_ch(0, 0, 0, 3, 0, 7);
    push(2'b00, 2'b01, "R7");
    for (int k = 0; k < 8; k++)  push(2'(model_bit(0, 3, 0, 7, k)), 2'b01, "R7");
    for (int k = 0; k < 24; k++) push(2'(model_bit(0, 6, 0, 11, k)), 2'b01, "R7");
    chan_en[0] = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    bus_wr(0, 1, 32'd6);
    bus_wr(0, 2, 32'd11);
    wait_drain();
    stop_ch(0);

    // R8: enable dropped in period 2 with stop mode 0: period finishes
    cfg_ch(0, 0, 0, 3, 0, 7);
    push(2'b00, 2'b01, "R8");
    for (int k = 0; k < 16; k++) push(2'(model_bit(0, 3, 0, 7, k)), 2'b01, "R8");
    for (int k = 0; k < 8; k++)  push(2'b00, 2'b01, "R8");
    chan_en[0] = 1'b1;
    repeat (10) @(posedge clk);
    #1;
    chan_en[0] = 1'b0;
    wait_drain();
    stop_ch(0);

    // R9: same timing with stop mode 1: low right after the next edge
    cfg_ch(0, 0, 1, 3, 0, 7);
    push(2'b00, 2'b01, "R9");
    for (int k = 0; k < 10; k++) push(2'(model_bit(0, 3, 0, 7, k)), 2'b01, "R9");
    for (int k = 0; k < 8; k++)  push(2'b00, 2'b01, "R9");
    chan_en[0] = 1'b1;
    repeat (10) @(posedge clk);
    #1;
    chan_en[0] = 1'b0;
    wait_drain();

    // R10: both channels at once with different settings
    cfg_ch(0, 0, 0, 3, 0, 7);
    cfg_ch(1, 1, 0, 1, 0, 2);
    push(2'b00, 2'b11, "R10");
    for (int k = 0; k < 24; k++)
      push({model_bit(1, 1, 0, 2, k), model_bit(0, 3, 0, 7, k)}, 2'b11, "R10");
    chan_en = 2'b11;
    wait_drain();
    stop_ch(0);
    stop_ch(1);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule